// File: doc/BRIEF.md
# Digital Audio Tape Start/Shortening Marker Detector

This block watches the user-data marker bits of a received digital audio stream. A marker is taken into account only while the channel status category code shows a tape stream carrying subcodes. A sync mark on the first indicator bit, together with exactly one of the two other indicator bits, names the marker. When the second bit is the one set, the marker is a start marker. When the third bit is the one set, it is a shortening marker. A valid marker drops the shared active-low ready line for a fixed number of cycles and records the result.

The host collects the result over the same serial read port that it uses for subcode readout. It raises a select line and clocks in an address, least significant bit first, using single-cycle shift enables. If the address matches, the block sends a frame of one flag bit followed by the payload bits. After a start marker the whole frame is ones. After a shortening marker, or when no marker is recorded, the whole frame is zeros. The frame value is captured when the address completes, so a result that changes during a read cannot split the frame.

Top module: `dat_id_detect`

## Requirements
- R1: The category code counts as the tape category only when its bits 7..1 equal 1100000. Bit 0 is ignored. Markers that arrive under any other code have no effect.
- R2: A strobe with indicator bits sync=1, second=1, third=0 under the tape category records a start marker. A matching read then returns FRAME_W = 81 consecutive ones.
- R3: A strobe with sync=1, second=0, third=1 under the tape category records a shortening marker. A matching read then returns 81 consecutive zeros.
- R4: A valid marker drives ready_n low from the clock edge that samples the strobe. It stays low for exactly PULSE_LEN (default 4) cycles and then returns high.
- R5: Any other indicator combination, including sync=0, gives no ready pulse and leaves the recorded result unchanged.
- R6: While the category code is not the tape category, the recorded result is cleared. Later reads return all zeros.
- R7: While sel is high, the first ADDR_W (8) shift enables load the address, least significant bit first. If it equals READ_ADDR (0x5A), serial_out presents the frame bits, and each further shift enable moves to the next bit. After the last frame bit, and whenever sel is low, serial_out is low.
- R8: A read whose address differs from READ_ADDR keeps serial_out low for the whole transfer.
- R9: The frame value is fixed at the shift enable that completes a matching address. A result change during the frame does not alter the remaining bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cat_code | input | 8 | Received channel status category code |
| ind_strobe | input | 1 | One-cycle strobe qualifying the indicator bits |
| ind_sync | input | 1 | Sync indicator bit |
| ind_start | input | 1 | Start indicator bit |
| ind_short | input | 1 | Shortening indicator bit |
| sel | input | 1 | Host read select, high during a transfer |
| shift_en | input | 1 | One-cycle host shift enable |
| serial_in | input | 1 | Host address bit |
| serial_out | output | 1 | Result frame bit |
| ready_n | output | 1 | Active-low marker ready pulse |

## Verification
The assertions assume that sel is low during reset and that indicator bits only matter in cycles where ind_strobe is high. The stimulus meets both assumptions. The stimulus also spaces strobes far enough apart that each ready pulse ends before the next marker arrives. This keeps pulse-length checks unambiguous. Category codes are drawn so that tape codes appear with both values of the ignored bit, and non-tape codes differ from the tape code in at least one compared bit.

// File: rtl/dat_id_pkg.sv
package dat_id_pkg;

   typedef enum logic [1:0] {
      MARK_NONE  = 2'd0,
      MARK_START = 2'd1,
      MARK_SHORT = 2'd2
   } mark_kind_t;

   // Sync must be set, and exactly one of the two other indicator bits.
   function automatic mark_kind_t classify_mark(input logic s, input logic a, input logic b);
      mark_kind_t k;
      k = MARK_NONE;
      if (s && a && !b) k = MARK_START;
      else if (s && !a && b) k = MARK_SHORT;
      return k;
   endfunction

endpackage

// File: rtl/dat_cat_gate.sv
module dat_cat_gate #(
   parameter int unsigned        CAT_W    = 8,
   parameter logic [CAT_W-1:0]   CAT_CODE = 8'b1100_0000,
   parameter logic [CAT_W-1:0]   CAT_MASK = 8'b1111_1110
) (
   input  logic [CAT_W-1:0] cat_code,
   output logic             is_tape
);
   localparam logic [CAT_W-1:0] CODE_M = CAT_CODE & CAT_MASK;

   always_comb begin
      is_tape = ((cat_code & CAT_MASK) == CODE_M);
   end
endmodule

// File: rtl/dat_mark_classify.sv
module dat_mark_classify
   import dat_id_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic is_tape,
   input  logic ind_strobe,
   input  logic ind_sync,
   input  logic ind_start,
   input  logic ind_short,
   output logic mark_hit,
   output logic res_start
);
   mark_kind_t kind;

   always_comb begin
      kind     = classify_mark(ind_sync, ind_start, ind_short);
      mark_hit = ind_strobe && is_tape && (kind != MARK_NONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_start <= 1'b0;
      end else if (!is_tape) begin
         res_start <= 1'b0;
      end else if (mark_hit) begin
         res_start <= (kind == MARK_START);
      end
   end
endmodule

// File: rtl/dat_ready_pulse.sv
module dat_ready_pulse #(
   parameter int unsigned PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic ready_n
);
   generate
      if (PULSE_LEN == 1) begin : g_single
         logic low_q;
         always_ff @(posedge clk) begin
            if (!rst_n) low_q <= 1'b0;
            else        low_q <= fire;
         end
         assign ready_n = !low_q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(PULSE_LEN + 1);
         localparam logic [CW-1:0] LEN_C = CW'(PULSE_LEN);
         logic [CW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              left_q <= '0;
            else if (fire)           left_q <= LEN_C;
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end
         assign ready_n = (left_q == '0);
      end
   endgenerate
endmodule

// File: rtl/dat_serial_read.sv
module dat_serial_read #(
   parameter int unsigned       ADDR_W         = 8,
   parameter logic [ADDR_W-1:0] READ_ADDR      = 8'h5A,
   parameter int unsigned       FRAME_W        = 81,
   parameter bit                ADDR_LSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic shift_en,
   input  logic serial_in,
   input  logic frame_val,
   output logic serial_out
);
   localparam int unsigned END_N = ADDR_W + FRAME_W;
   localparam int unsigned CNT_W = $clog2(END_N + 1);
   localparam logic [CNT_W-1:0] ADDR_END  = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(END_N);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic              match_q;
   logic              snap_q;

   generate
      if (ADDR_W == 1) begin : g_one
         assign addr_nxt = serial_in;
      end else if (ADDR_LSB_FIRST) begin : g_lsb
         assign addr_nxt = {serial_in, addr_q[ADDR_W-1:1]};
      end else begin : g_msb
         assign addr_nxt = {addr_q[ADDR_W-2:0], serial_in};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !sel) begin
         cnt_q   <= '0;
         addr_q  <= '0;
         match_q <= 1'b0;
         snap_q  <= 1'b0;
      end else if (shift_en) begin
         if (cnt_q < ADDR_END) begin
            addr_q <= addr_nxt;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == ADDR_LAST) begin
               match_q <= (addr_nxt == READ_ADDR);
               snap_q  <= frame_val;
            end
         end else if (match_q && (cnt_q < FRAME_END)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      serial_out = sel && match_q && (cnt_q >= ADDR_END) && (cnt_q < FRAME_END) && snap_q;
   end
endmodule

// File: rtl/dat_id_detect.sv
module dat_id_detect #(
   parameter int unsigned        CAT_W          = 8,
   parameter logic [CAT_W-1:0]   CAT_CODE       = 8'b1100_0000,
   parameter logic [CAT_W-1:0]   CAT_MASK       = 8'b1111_1110,
   parameter int unsigned        PAYLOAD_W      = 80,
   parameter int unsigned        ADDR_W         = 8,
   parameter logic [ADDR_W-1:0]  READ_ADDR      = 8'h5A,
   parameter bit                 ADDR_LSB_FIRST = 1'b1,
   parameter int unsigned        PULSE_LEN      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CAT_W-1:0] cat_code,
   input  logic             ind_strobe,
   input  logic             ind_sync,
   input  logic             ind_start,
   input  logic             ind_short,
   input  logic             sel,
   input  logic             shift_en,
   input  logic             serial_in,
   output logic             serial_out,
   output logic             ready_n
);
   localparam int unsigned FRAME_W = PAYLOAD_W + 1;

   generate
      if (CAT_W < 1)     begin : g_bad_cat   $error("CAT_W must be at least 1");     end
      if (ADDR_W < 1)    begin : g_bad_addr  $error("ADDR_W must be at least 1");    end
      if (PAYLOAD_W < 1) begin : g_bad_pay   $error("PAYLOAD_W must be at least 1"); end
      if (PULSE_LEN < 1) begin : g_bad_pulse $error("PULSE_LEN must be at least 1"); end
   endgenerate

   logic is_tape;
   logic mark_hit;
   logic res_start;

   dat_cat_gate #(
      .CAT_W(CAT_W), .CAT_CODE(CAT_CODE), .CAT_MASK(CAT_MASK)
   ) u_gate (
      .cat_code(cat_code), .is_tape(is_tape)
   );

   dat_mark_classify u_cls (
      .clk(clk), .rst_n(rst_n), .is_tape(is_tape),
      .ind_strobe(ind_strobe), .ind_sync(ind_sync),
      .ind_start(ind_start), .ind_short(ind_short),
      .mark_hit(mark_hit), .res_start(res_start)
   );

   dat_ready_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(mark_hit), .ready_n(ready_n)
   );

   dat_serial_read #(
      .ADDR_W(ADDR_W), .READ_ADDR(READ_ADDR),
      .FRAME_W(FRAME_W), .ADDR_LSB_FIRST(ADDR_LSB_FIRST)
   ) u_read (
      .clk(clk), .rst_n(rst_n), .sel(sel), .shift_en(shift_en),
      .serial_in(serial_in), .frame_val(res_start), .serial_out(serial_out)
   );
endmodule

// File: rtl/dat_id_detect_chk.sv
module dat_id_detect_chk #(
   parameter int unsigned      CAT_W    = 8,
   parameter logic [CAT_W-1:0] CAT_CODE = 8'b1100_0000,
   parameter logic [CAT_W-1:0] CAT_MASK = 8'b1111_1110
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CAT_W-1:0] cat_code,
   input logic             ind_strobe,
   input logic             ind_sync,
   input logic             ind_start,
   input logic             ind_short,
   input logic             sel,
   input logic             serial_out,
   input logic             ready_n,
   input logic             res_start
);
   logic tape_c;
   logic good_c;
   assign tape_c = ((cat_code & CAT_MASK) == (CAT_CODE & CAT_MASK));
   assign good_c = ind_strobe && tape_c && ind_sync && (ind_start != ind_short);

   // R4: a valid marker pulls ready_n low on the next cycle
   a_r4_pulse_begins: assert property (@(posedge clk) disable iff (!rst_n)
      good_c |=> !ready_n);

   // R1 R5: with ready_n idle and no valid marker, ready_n stays high
   a_r5_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_n && !good_c) |=> ready_n);

   // R6: a non-tape category leaves the result cleared
   a_r6_clear_off_tape: assert property (@(posedge clk) disable iff (!rst_n)
      !tape_c |=> !res_start);

   // R5: without a valid marker under the tape category, the result holds
   a_r5_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (tape_c && !good_c) |=> $stable(res_start));

   // R2 R3: a valid marker sets the result to its kind
   a_r2_start_records: assert property (@(posedge clk) disable iff (!rst_n)
      (good_c && ind_start) |=> res_start);
   a_r3_short_records: assert property (@(posedge clk) disable iff (!rst_n)
      (good_c && ind_short) |=> !res_start);

   // R7: serial_out is low while sel is low
   a_r7_quiet_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !serial_out);
endmodule

bind dat_id_detect dat_id_detect_chk #(
   .CAT_W(CAT_W), .CAT_CODE(CAT_CODE), .CAT_MASK(CAT_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cat_code(cat_code), .ind_strobe(ind_strobe),
   .ind_sync(ind_sync), .ind_start(ind_start), .ind_short(ind_short),
   .sel(sel), .serial_out(serial_out), .ready_n(ready_n), .res_start(res_start)
);

// File: tb/tb_dat_id_detect.sv
module tb_dat_id_detect;
   localparam int FRAME = 81;
   localparam int AW    = 8;
   localparam logic [7:0] RADDR = 8'h5A;
   localparam int PLEN  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] cat_code = 8'h00;
   logic ind_strobe = 1'b0, ind_sync = 1'b0, ind_start = 1'b0, ind_short = 1'b0;
   logic sel = 1'b0, shift_en = 1'b0, serial_in = 1'b0;
   logic serial_out, ready_n;

   int total = 0;
   int bad = 0;
   bit exp_start = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dat_id_detect dut (
      .clk(clk), .rst_n(rst_n), .cat_code(cat_code), .ind_strobe(ind_strobe),
      .ind_sync(ind_sync), .ind_start(ind_start), .ind_short(ind_short),
      .sel(sel), .shift_en(shift_en), .serial_in(serial_in),
      .serial_out(serial_out), .ready_n(ready_n)
   );

   function automatic bit is_tape(input logic [7:0] c);
      return c[7:1] == 7'b1100000;
   endfunction

   function automatic bit good_mark(input logic [7:0] c, input bit s, input bit a, input bit b);
      return is_tape(c) && s && (a != b);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_cat(input logic [7:0] c);
      @(negedge clk);
      cat_code = c;
      if (!is_tape(c)) exp_start = 1'b0;
      @(negedge clk);
   endtask

   // Strobe a marker and verify the ready pulse shape (R4/R5).
   task automatic mark(input bit s, input bit a, input bit b, input string req);
      bit g;
      int lows;
      g = good_mark(cat_code, s, a, b);
      @(negedge clk);
      ind_strobe = 1'b1; ind_sync = s; ind_start = a; ind_short = b;
      @(negedge clk);
      ind_strobe = 1'b0; ind_sync = 1'b0; ind_start = 1'b0; ind_short = 1'b0;
      lows = 0;
      for (int i = 0; i < PLEN + 2; i++) begin
         if (!ready_n) lows++;
         @(negedge clk);
      end
      check(req, lows, g ? PLEN : 0);
      if (g) exp_start = a;
   endtask

   task automatic send_addr(input logic [7:0] addr);
      @(negedge clk);
      sel = 1'b1;
      for (int i = 0; i < AW; i++) begin
         @(negedge clk);
         serial_in = addr[i]; shift_en = 1'b1;
         @(negedge clk);
         shift_en = 1'b0;
      end
   endtask

   // Sample n frame bits, advancing between samples; returns count of ones.
   task automatic take_bits(input int n, output int ones);
      ones = 0;
      for (int i = 0; i < n; i++) begin
         if (serial_out) ones++;
         shift_en = 1'b1;
         @(negedge clk);
         shift_en = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic end_read();
      sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic read_check(input string req);
      int ones;
      send_addr(RADDR);
      take_bits(FRAME, ones);
      check(req, ones, exp_start ? FRAME : 0);
      check("R7 trailing", int'(serial_out), 0);
      end_read();
      check("R7 unselected", int'(serial_out), 0);
   endtask

   task automatic read_wrong(input logic [7:0] addr);
      int ones;
      send_addr(addr);
      take_bits(FRAME, ones);
      check("R8 wrong address", ones, 0);
      end_read();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int ones;
      void'($urandom(32'd7731));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("reset ready_n", int'(ready_n), 1);
      check("reset serial_out", int'(serial_out), 0);
      read_check("R6 reset reads zeros");

      // Directed: start marker, tape code with ignored bit set (R1, R2)
      set_cat(8'b1100_0001);
      mark(1, 1, 0, "R4 start pulse");
      read_check("R2 start frame");
      // R5: invalid combos keep the result and give no pulse
      mark(0, 1, 0, "R5 no sync");
      mark(1, 1, 1, "R5 both set");
      read_check("R5 result kept");
      // R3 shortening
      set_cat(8'b1100_0000);
      mark(1, 0, 1, "R3 short pulse");
      read_check("R3 short frame");
      // R1: non-tape code ignores markers
      mark(1, 1, 0, "R4 start again");
      set_cat(8'b1100_0010);
      read_check("R6 cleared off tape");
      mark(1, 1, 0, "R1 non-tape no pulse");
      read_check("R1 non-tape no result");
      // R9: frame value fixed at address completion
      set_cat(8'b1100_0000);
      mark(1, 1, 0, "R4 start for snapshot");
      send_addr(RADDR);
      take_bits(20, ones);
      cat_code = 8'h00;
      repeat (3) @(negedge clk);
      begin
         int more;
         take_bits(FRAME - 20, more);
         check("R9 frame held", ones + more, FRAME);
      end
      exp_start = 1'b0;
      end_read();
      set_cat(8'b1100_0000);
      mark(1, 1, 0, "R4 start before wrong read");
      read_wrong(RADDR ^ 8'h01);
      read_wrong(RADDR ^ 8'h80);

      // Constrained random
      for (int it = 0; it < 90; it++) begin
         logic [7:0] c;
         if ($urandom_range(0, 9) < 7) c = {7'b1100000, 1'($urandom_range(0, 1))};
         else begin
            c = 8'($urandom_range(0, 255));
            if (is_tape(c)) c[7] = 1'b0;
         end
         set_cat(c);
         mark(1'($urandom_range(0, 1)) | 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4 R5 random pulse");
         if (it % 4 == 0) read_check("R2 R3 random frame");
         if (it % 9 == 0) read_wrong(RADDR ^ (8'd1 << $urandom_range(0, 7)));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule